// File: doc/BRIEF.md
# Sequential Integer and Fraction Divider

The block is a 16-bit unsigned divider with two modes. It makes one restoring trial subtraction per clock. In integer mode it divides a dividend by a divisor and returns a quotient and a remainder. In fraction mode the numerator is treated as if it were shifted up by sixteen bit positions. The quotient is then a binary-weighted fraction below one, from zero up to about 0.99998, and the leftover is returned as a remainder.

A host raises `start` for one cycle with the mode and the operands. The block copies the operands at that edge and raises `busy`. It raises `done` for exactly one cycle when the result ports hold the new answer. Some operand pairs cannot produce a valid quotient: a zero divisor, or a fraction-mode numerator that is not below its denominator. The block resolves these at once and raises flags for them.

A three-state machine controls the block:
- **IDLE**: waiting for work. `start` here is accepted.
  - Transition *accept-slow* goes from IDLE to RUN.
  - Transition *accept-fast* goes from IDLE straight to DONE when the pair is exceptional.
- **RUN**: produces one quotient bit per clock.
  - Transition *iterate* stays in RUN.
  - Transition *last-bit* goes to DONE after the final bit.
- **DONE**: the one-cycle completion state.
  - Transition *retire* returns to IDLE.

Top module: `divq_unit`

## Requirements
- R1: In integer mode (`frac_mode`=0) with a nonzero divisor, `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor. `flag_ovf` and `flag_carry` are both 0.
- R2: In fraction mode (`frac_mode`=1) with numerator < denominator, `quotient` = floor(numerator·65536 / denominator) and `remainder` = (numerator·65536) mod denominator. Both flags are 0.
- R3: A zero divisor in either mode gives `flag_carry`=1, `flag_ovf`=0, `quotient`=0xFFFF and `remainder` = the dividend.
- R4: In fraction mode with a nonzero denominator and numerator ≥ denominator, the block gives `flag_ovf`=1, `flag_carry`=0, `quotient`=0xFFFF and `remainder` = the numerator.
- R5: While `done` is high, `flag_zero` is 1 exactly when `quotient` is 0x0000.
- R6: A normal division raises `done` 16 clock edges after the edge that accepts `start`. An exceptional pair (R3, R4) raises `done` right after the accepting edge.
- R7: `done` is high for exactly one cycle. `busy` is high from the accepting edge through the `done` cycle, and it is low when idle.
- R8: `start` while `busy` is high is ignored, including during the `done` cycle. Operand inputs that change after acceptance have no effect on the result.
- R9: The result and flag outputs keep their values after `done` until the next completion.
- R10: After reset, `busy`, `done`, `quotient`, `remainder` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| frac_mode | input | 1 | 0 = integer divide, 1 = fraction divide |
| dividend | input | 16 | Dividend or numerator |
| divisor | input | 16 | Divisor or denominator |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient or fraction |
| remainder | output | 16 | Remainder |
| flag_zero | output | 1 | Quotient is zero |
| flag_ovf | output | 1 | Fraction-mode numerator not below denominator |
| flag_carry | output | 1 | Division by zero |

## Verification
Two events can fall in the same cycle: the `done` pulse of one division and a fresh `start` with new operands. A second case is a `start` arriving while the machine is still in RUN, together with operand changes. The bench drives these on purpose. It pulses `start` mid-run with different operands, and it pulses `start` again in the exact cycle where `done` is high. It then checks that `busy` stays low in the following cycle and that the outputs still show the first division's answer.

// File: rtl/divq_pkg.sv
package divq_pkg;
    parameter int DQ_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dq_state_t;
endpackage

// File: rtl/divq_ctrl.sv
module divq_ctrl
    import divq_pkg::*;
#(
    parameter int W = DQ_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic special,
    output logic load,
    output logic step,
    output logic fin_fast,
    output logic fin_slow,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    dq_state_t state, state_nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (load)
                cnt <= '0;
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = special ? ST_DONE : ST_RUN;
            ST_RUN:  if (cnt == LAST) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = (state == ST_IDLE) && start;
        fin_fast = load && special;
        step     = (state == ST_RUN);
        fin_slow = step && (cnt == LAST);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R7
    AST_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        fin_fast |=> done); // R6
endmodule

// File: rtl/divq_datapath.sv
module divq_datapath
    import divq_pkg::*;
#(
    parameter int W = DQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         busy,
    input  logic         start,
    input  logic         frac_mode,
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    output logic         special,
    output logic [W-1:0] q_next,
    output logic [W-1:0] r_next,
    output logic [W-1:0] den_q
);
    logic [W:0]   r_reg;
    logic [W-1:0] q_reg;
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         neg;

    assign special = (den_in == '0) || (frac_mode && (num_in >= den_in));

    always_comb begin
        shifted = {r_reg[W-1:0], q_reg[W-1]};
        diff    = {1'b0, shifted} - {2'b00, den_q};
        neg     = diff[W+1];
        q_next  = {q_reg[W-2:0], ~neg};
        r_next  = neg ? shifted[W-1:0] : diff[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_reg <= '0;
            q_reg <= '0;
            den_q <= '0;
        end else if (load) begin
            den_q <= den_in;
            if (frac_mode) begin
                r_reg <= {1'b0, num_in};
                q_reg <= '0;
            end else begin
                r_reg <= '0;
                q_reg <= num_in;
            end
        end else if (step) begin
            r_reg <= neg ? shifted : diff[W:0];
            q_reg <= q_next;
        end
    end

    AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(den_q)); // R8
    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> r_reg < {1'b0, den_q}); // R1
endmodule

// File: rtl/divq_unit.sv
module divq_unit
    import divq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        frac_mode,
    input  logic [15:0] dividend,
    input  logic [15:0] divisor,
    output logic        busy,
    output logic        done,
    output logic [15:0] quotient,
    output logic [15:0] remainder,
    output logic        flag_zero,
    output logic        flag_ovf,
    output logic        flag_carry
);
    localparam int W = DQ_W;

    logic         load, step, fin_fast, fin_slow, special;
    logic [W-1:0] q_next, r_next, den_q;

    divq_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .special(special),
        .load(load), .step(step), .fin_fast(fin_fast), .fin_slow(fin_slow),
        .busy(busy), .done(done)
    );

    divq_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .busy(busy),
        .start(start), .frac_mode(frac_mode), .num_in(dividend),
        .den_in(divisor), .special(special), .q_next(q_next),
        .r_next(r_next), .den_q(den_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient   <= '0;
            remainder  <= '0;
            flag_zero  <= 1'b0;
            flag_ovf   <= 1'b0;
            flag_carry <= 1'b0;
        end else if (fin_fast) begin
            quotient   <= '1;
            remainder  <= dividend;
            flag_zero  <= 1'b0;
            flag_carry <= (divisor == '0);
            flag_ovf   <= (divisor != '0);
        end else if (fin_slow) begin
            quotient   <= q_next;
            remainder  <= r_next;
            flag_zero  <= (q_next == '0);
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
        end
    end

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag_zero == (quotient == '0)); // R5
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_carry |-> quotient == '1 && !flag_ovf); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_ovf |-> quotient == '1 && !flag_carry); // R4
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !flag_ovf && !flag_carry |-> remainder < den_q); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done && !$past(fin_fast) |=> $stable(quotient) || done); // R9
endmodule

// File: tb/test_divq_unit.sv
`timescale 1ns/1ps
module test_divq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, flag_zero, flag_ovf, flag_carry;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    divq_unit i_divq_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .flag_zero(flag_zero),
        .flag_ovf(flag_ovf), .flag_carry(flag_carry)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_special(bit fm, logic [15:0] a, logic [15:0] b);
        return (b == 0) || (fm && a >= b);
    endfunction

    function automatic logic [15:0] exp_q(bit fm, logic [15:0] a, logic [15:0] b);
        logic [31:0] n;
        if (is_special(fm, a, b)) return 16'hFFFF;
        n = fm ? {a, 16'h0000} : {16'h0000, a};
        return 16'(n / {16'h0000, b});
    endfunction

    function automatic logic [15:0] exp_r(bit fm, logic [15:0] a, logic [15:0] b);
        logic [31:0] n;
        if (is_special(fm, a, b)) return a;
        n = fm ? {a, 16'h0000} : {16'h0000, a};
        return 16'(n % {16'h0000, b});
    endfunction

    // Issue one division. poke=1: start with other operands mid-run (R8).
    // poke=2: start again in the done cycle (R8).
    task automatic run_div(input bit fm, input logic [15:0] a, input logic [15:0] b, input int poke);
        int n;
        bit sp;
        logic [15:0] eq, er;
        sp = is_special(fm, a, b);
        eq = exp_q(fm, a, b);
        er = exp_r(fm, a, b);
        @(negedge clk);
        frac_mode = fm; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = b + 16'd3; frac_mode = ~fm;   // R8: late operand change
        n = 0;
        check(busy == 1'b1, "R7 busy after accept", busy, 1);
        while (!done && n < 40) begin
            if (poke == 1 && n == 4) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check(n == (sp ? 0 : 16), "R6 latency", n, sp ? 0 : 16);
        check(quotient == eq, fm ? "R2 quotient" : "R1 quotient", quotient, eq);
        check(remainder == er, fm ? "R2 remainder" : "R1 remainder", remainder, er);
        check(flag_carry == (b == 0), "R3 carry flag", flag_carry, b == 0);
        check(flag_ovf == (b != 0 && sp), "R4 overflow flag", flag_ovf, b != 0 && sp);
        check(flag_zero == (eq == 0), "R5 zero flag", flag_zero, eq == 0);
        if (poke == 2) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 done one cycle", done, 0);
        check(busy == 1'b0, "R8 start ignored in done cycle", busy, 0);
        @(negedge clk);
        check(quotient == eq && remainder == er, "R9 result held", quotient, eq);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        logic [15:0] a, b;
        bit fm;
        a = 16'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 0 && done == 0, "R10 reset handshake", {busy, done}, 0);
        check(quotient == 0 && remainder == 0, "R10 reset results", {quotient, remainder}, 0);
        check({flag_zero, flag_ovf, flag_carry} == 0, "R10 reset flags", {flag_zero, flag_ovf, flag_carry}, 0);
        rst_n = 1'b1;
        // directed corner cases
        run_div(0, 16'd1000, 16'd7, 0);      // R1
        run_div(0, 16'hFFFF, 16'd1, 0);      // R1
        run_div(0, 16'd0, 16'd5, 0);         // R1, R5
        run_div(0, 16'd3, 16'd9, 0);         // R1, R5
        run_div(0, 16'hFFFF, 16'hFFFF, 0);   // R1
        run_div(1, 16'd1, 16'd2, 0);         // R2
        run_div(1, 16'd1, 16'd3, 0);         // R2
        run_div(1, 16'hFFFE, 16'hFFFF, 0);   // R2
        run_div(1, 16'd0, 16'd77, 0);        // R2, R5
        run_div(0, 16'd1234, 16'd0, 0);      // R3
        run_div(1, 16'd55, 16'd0, 0);        // R3
        run_div(1, 16'd40, 16'd40, 0);       // R4
        run_div(1, 16'hF000, 16'h0100, 0);   // R4
        run_div(0, 16'd5000, 16'd13, 1);     // R8 mid-run start
        run_div(1, 16'd9, 16'd11, 2);        // R8 start during done
        run_div(0, 16'd0, 16'd0, 2);         // R3, R8
        // constrained random
        for (int i = 0; i < 300; i++) begin
            fm = 1'($urandom);
            b = 16'($urandom);
            if ($urandom % 8 == 0) b = 16'($urandom % 4);
            if (fm && b != 0 && ($urandom % 6 != 0)) a = 16'($urandom % b);
            else a = 16'($urandom);
            run_div(fm, a, b, int'($urandom % 3));
        end
        report();
    end
endmodule